// File: doc/BRIEF.md
# GPIO Pin Control and Interrupt Register Bank

This block is the software-visible control state of one 32-pin general-purpose port. Each pin owns a control word holding sixteen bits of general configuration, a four-bit interrupt mode and an interrupt flag. Software reaches every word over a simple synchronous bus with a word address. Reads are combinational on the selected address. Writes take effect at the next rising clock edge.

Two global-write words let one bus write load the same sixteen-bit value into the low half of many pin words in a single cycle. One word serves pins 0 to 15 and the other serves pins 16 to 31. Any pin whose lock bit is set is skipped. Pin inputs are synchronized and then compared against each pin's interrupt mode to set the flags. A flag can be read in the pin's own word or in a 32-bit flag word, and it can be cleared from either one. A single interrupt line reports when any flag is set.

Top module: `pin_ctl_bank`

## Requirements
- R1: After reset every pin word and the flag word read as zero, and `irq` is low.
- R2: The pin word at word address n (byte offset 4n, n = 0..31) reads as: bits 15:0 general field, bits 19:16 interrupt mode, bit 24 flag, and every other bit zero. A write stores bits 15:0 and 19:16 from the bus.
- R3: Bit 15 of a pin word is its lock. While it is set, bits 15:0 of that word ignore every write until reset. Bits 19:16 stay writable.
- R4: A write to word address 32 (byte offset 0x80) replaces bits 15:0 of pin word k (k = 0..15) with wdata[15:0] wherever wdata[16+k] is 1. A write to word address 33 (byte offset 0x84) does the same for pin word 16+k under wdata[16+k]. All enabled words update in the same cycle.
- R5: A global write leaves a locked pin word unchanged even when its enable bit is set.
- R6: Word addresses 32 and 33 read as zero, and so does any address that is not mapped.
- R7: Word address 40 (byte offset 0xA0) reads the 32 flags with pin n at bit n. Writing 1 to bit n clears that flag. Writing 0 to a bit leaves the flag unchanged.
- R8: Writing a pin word with bit 24 set clears that pin's flag. It is the same storage bit that the flag word shows.
- R9: The interrupt mode codes are: 0 off, 1 rising edge, 2 falling edge, 3 either edge, 4 level low, 5 level high. Codes 6 to 15 are off. Pin inputs pass through two synchronizing flops before detection, and a flag is set no later than the fourth rising edge after the pin changes.
- R10: When detection and a software clear hit the same flag in the same cycle, the flag ends up set.
- R11: `irq` is high exactly when at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is selected |
| pin_in | input | 32 | Asynchronous pin levels |
| irq | output | 1 | OR of all flags |

## Verification
The assertions assume that the bus controls are never unknown once reset is released, and that any change to a flag or to a mode field is caused either by detection or by a bus write in the previous cycle. The stimulus keeps the pins low through reset, so the edge history does not start with a false rising edge. It drives the bus and the pins only on falling clock edges and moves one pin at a time. After each pin change it waits five cycles, which is longer than the synchronizer and detection latency.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int unsigned LOW_W     = 16;
  localparam int unsigned LOCK_BIT  = 15;
  localparam int unsigned MODE_LSB  = 16;
  localparam int unsigned MODE_W    = 4;
  localparam int unsigned FLAG_BIT  = 24;
  localparam int unsigned WA_GLOW   = 32;
  localparam int unsigned WA_GHIGH  = 33;
  localparam int unsigned WA_FLAGS  = 40;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF  = 4'd0,
    MODE_RISE = 4'd1,
    MODE_FALL = 4'd2,
    MODE_BOTH = 4'd3,
    MODE_LOW  = 4'd4,
    MODE_HIGH = 4'd5
  } irq_mode_e;
endpackage

// File: rtl/pcb_sync.sv
module pcb_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign cur  = sync_q;
  assign prev = hist_q;
endmodule

// File: rtl/pcb_detect.sv
module pcb_detect import pcb_pkg::*; #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0]             cur,
  input  logic [NPINS-1:0]             prev,
  input  logic [NPINS-1:0][MODE_W-1:0] mode,
  output logic [NPINS-1:0]             hit
);
  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      unique case (mode[i])
        MODE_RISE: hit[i] = cur[i] & ~prev[i];
        MODE_FALL: hit[i] = ~cur[i] & prev[i];
        MODE_BOTH: hit[i] = cur[i] ^ prev[i];
        MODE_LOW:  hit[i] = ~cur[i];
        MODE_HIGH: hit[i] = cur[i];
        default:   hit[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pcb_pin_reg.sv
module pcb_pin_reg import pcb_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              own_wr,
  input  logic              glob_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ext_clr,
  input  logic              hw_set,
  output logic [LOW_W-1:0]  low_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              flag_q
);
  logic [LOW_W-1:0]  low_d;
  logic [MODE_W-1:0] mode_d;
  logic              flag_d;
  logic              low_en, mode_en, clr;

  always_comb begin
    low_en  = (own_wr | glob_wr) & ~low_q[LOCK_BIT];
    mode_en = own_wr;
    low_d   = wdata[LOW_W-1:0];
    mode_d  = wdata[MODE_LSB +: MODE_W];
    clr     = ext_clr | (own_wr & wdata[FLAG_BIT]);
    flag_d  = hw_set | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      mode_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (low_en)  low_q  <= low_d;
      if (mode_en) mode_q <= mode_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/pin_ctl_bank.sv
module pin_ctl_bank import pcb_pkg::*; #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic              irq
);
  localparam int HALF  = NPINS / 2;
  localparam int IDX_W = $clog2(NPINS);

  logic wr_go, glow_wr, ghigh_wr, flags_wr;
  logic [NPINS-1:0] own_wr, glob_en, ext_clr, hit_vec, flag_vec;
  logic [NPINS-1:0] pin_cur, pin_prev;
  logic [NPINS-1:0][MODE_W-1:0] mode_vec;
  logic [NPINS-1:0][LOW_W-1:0]  low_vec;
  logic [NPINS*LOW_W-1:0]  low_flat;
  logic [NPINS*MODE_W-1:0] cfg_flat;
  logic [DATA_W-1:0] pcr_word [NPINS];

  assign wr_go    = bus_sel & bus_wr;
  assign glow_wr  = wr_go & (bus_addr == ADDR_W'(WA_GLOW));
  assign ghigh_wr = wr_go & (bus_addr == ADDR_W'(WA_GHIGH));
  assign flags_wr = wr_go & (bus_addr == ADDR_W'(WA_FLAGS));

  pcb_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .cur(pin_cur), .prev(pin_prev)
  );

  pcb_detect #(.NPINS(NPINS)) u_detect (
    .cur(pin_cur), .prev(pin_prev), .mode(mode_vec), .hit(hit_vec)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign own_wr[i]  = wr_go & (bus_addr == ADDR_W'(i));
    assign ext_clr[i] = flags_wr & bus_wdata[i];
    if (i < HALF) begin : g_lo
      assign glob_en[i] = glow_wr & bus_wdata[LOW_W + i];
    end else begin : g_hi
      assign glob_en[i] = ghigh_wr & bus_wdata[LOW_W + i - HALF];
    end

    pcb_pin_reg #(.DATA_W(DATA_W)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .own_wr(own_wr[i]), .glob_wr(glob_en[i]), .wdata(bus_wdata),
      .ext_clr(ext_clr[i]), .hw_set(hit_vec[i]),
      .low_q(low_vec[i]), .mode_q(mode_vec[i]), .flag_q(flag_vec[i])
    );

    always_comb begin
      pcr_word[i] = '0;
      pcr_word[i][LOW_W-1:0] = low_vec[i];
      pcr_word[i][MODE_LSB +: MODE_W] = mode_vec[i];
      pcr_word[i][FLAG_BIT] = flag_vec[i];
    end

    assign low_flat[i*LOW_W +: LOW_W]   = low_vec[i];
    assign cfg_flat[i*MODE_W +: MODE_W] = mode_vec[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr < ADDR_W'(NPINS))
        bus_rdata = pcr_word[bus_addr[IDX_W-1:0]];
      else if (bus_addr == ADDR_W'(WA_FLAGS))
        bus_rdata = DATA_W'(flag_vec);
    end
  end

  assign irq = |flag_vec;
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker import pcb_pkg::*; #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_sel,
  input logic                    bus_wr,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [DATA_W-1:0]       bus_rdata,
  input logic [NPINS*LOW_W-1:0]  low_flat,
  input logic [NPINS*MODE_W-1:0] cfg_flat,
  input logic [NPINS-1:0]        flag_vec,
  input logic [NPINS-1:0]        hit_vec
);
  a_r6_global_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == ADDR_W'(WA_GLOW) || bus_addr == ADDR_W'(WA_GHIGH)))
      |-> (bus_rdata == '0));

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      low_flat[i*LOW_W + LOCK_BIT] |=> $stable(low_flat[i*LOW_W +: LOW_W]));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[i] |=> flag_vec[i]);

    a_r9_rise_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_vec[i]) |-> $past(hit_vec[i]));

    a_r7_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_vec[i]) |-> $past(bus_sel && bus_wr));

    a_r2_mode_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_flat[i*MODE_W +: MODE_W]) |-> $past(bus_sel && bus_wr));
  end
endmodule

bind pin_ctl_bank pcb_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .low_flat(low_flat),
  .cfg_flat(cfg_flat), .flag_vec(flag_vec), .hit_vec(hit_vec)
);

// File: tb/sim_pin_ctl_bank.sv
module sim_pin_ctl_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic clk, rst_n, bus_sel, bus_wr, irq;
  logic [5:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, pin_in;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [15:0] m_low [NP];
  logic [3:0]  m_mode [NP];

  pin_ctl_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .irq(irq)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = 6'(a);
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic pcr_write(input int p, input logic [31:0] d);
    bus_write(p, d);
    if (!m_low[p][15]) m_low[p] = d[15:0];
    m_mode[p] = d[19:16];
  endtask

  function automatic logic [31:0] pcr_exp(input int p, input logic f);
    return {7'b0, f, 4'b0, m_mode[p], m_low[p]};
  endfunction

  task automatic check_all_pcr(input string req);
    logic [31:0] d;
    for (int p = 0; p < NP; p++) begin
      bus_read(p, d);
      check(req, d, pcr_exp(p, 1'b0));
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    wait_cyc(3);
    rst_n = 1;
    for (int p = 0; p < NP; p++) begin m_low[p] = '0; m_mode[p] = '0; end
    wait_cyc(1);
  endtask

  function automatic bit in_set(input int c, input int a, input int b, input int e, input int f);
    return (c == a) || (c == b) || (c == e) || (c == f);
  endfunction

  task automatic flag_step(input string req, input int p, input bit e);
    logic [31:0] d, ev;
    ev = e ? (32'h1 << p) : 32'h0;
    bus_read(40, d);
    check(req, d, ev);
    check("R11 irq", {31'b0, irq}, {31'b0, e});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    do_reset();

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check_all_pcr("R1 pin word");
    bus_read(40, d); check("R1 flags", d, 32'h0);

    // R2 direct write and field layout
    for (int p = 0; p < NP; p++)
      pcr_write(p, {7'h7F, 1'b0, 4'hF, 4'h0, 1'b0, 15'((p * 1237 + 91) & 16'h7FFF)});
    check_all_pcr("R2 layout");

    // R6 global words and unmapped addresses read zero
    foreach (d[i]) ;
    bus_read(32, d); check("R6 glow read", d, 32'h0);
    bus_read(33, d); check("R6 ghigh read", d, 32'h0);
    bus_read(34, d); check("R6 unmapped", d, 32'h0);
    bus_read(63, d); check("R6 unmapped", d, 32'h0);

    // R4 global writes, low and high halves
    bus_write(32, {16'hA5C3, 16'h1234});
    for (int k = 0; k < 16; k++) if ((16'hA5C3 >> k) & 1) m_low[k] = 16'h1234;
    check_all_pcr("R4 global low");
    bus_write(33, {16'h3C5A, 16'h4321});
    for (int k = 0; k < 16; k++) if ((16'h3C5A >> k) & 1) m_low[16+k] = 16'h4321;
    check_all_pcr("R4 global high");

    // R3 lock: set on pins 3, 20, 31
    pcr_write(3,  32'h0000_8003);
    pcr_write(20, 32'h0000_8014);
    pcr_write(31, 32'h0000_801F);
    pcr_write(3,  32'h0001_1111);
    bus_read(3, d); check("R3 lock keeps low, mode writable", d, 32'h0001_8003);
    pcr_write(3,  32'h0000_2222);
    bus_read(3, d); check("R3 lock keeps low", d, 32'h0000_8003);

    // R5 global write skips locked pins
    bus_write(32, {16'hFFFF, 16'h0F0F});
    for (int k = 0; k < 16; k++) if (!m_low[k][15]) m_low[k] = 16'h0F0F;
    bus_write(33, {16'hFFFF, 16'h7070});
    for (int k = 16; k < 32; k++) if (!m_low[k][15]) m_low[k] = 16'h7070;
    check_all_pcr("R5 locked skipped");

    // R9/R10/R11 mode sweep on three pins
    for (int s = 0; s < 3; s++) begin
      int p;
      p = (s == 0) ? 0 : (s == 1) ? 17 : 31;
      for (int c = 0; c < 8; c++) begin
        pin_in[p] = 0; wait_cyc(5);
        bus_write(40, 32'hFFFF_FFFF);
        pcr_write(p, {12'h0, 4'(c), m_low[p]});
        wait_cyc(5);
        flag_step("R9 quiet low", p, c == 4);
        bus_write(40, 32'h1 << p);
        flag_step("R10 clear vs level low", p, c == 4);
        bus_write(40, 32'hFFFF_FFFF);
        pin_in[p] = 1; wait_cyc(5);
        flag_step("R9 after rise", p, in_set(c, 1, 3, 4, 5));
        bus_write(40, 32'h1 << p);
        flag_step("R10 clear vs level high", p, c == 5);
        pin_in[p] = 0; wait_cyc(5);
        flag_step("R9 after fall", p, in_set(c, 2, 3, 4, 5));
        bus_read(p, d);
        check("R8 flag in pin word", {31'b0, d[24]}, {31'b0, in_set(c, 2, 3, 4, 5)});
        bus_write(40, 32'hFFFF_FFFF);
        wait_cyc(5);
        flag_step("R9 settled low", p, c == 4);
        pcr_write(p, {12'h0, 4'h0, m_low[p]});
        bus_write(40, 32'hFFFF_FFFF);
        wait_cyc(3);
      end
    end

    // R7/R8 dual clear paths on pin 5, rising mode
    pcr_write(5, {12'h0, 4'h1, m_low[5]});
    pin_in[5] = 1; wait_cyc(5);
    flag_step("R9 rise pin5", 5, 1);
    bus_write(40, 32'hFFFF_FFDF);
    flag_step("R7 write zero no effect", 5, 1);
    bus_write(5, {7'h0, 1'b1, 4'h0, 4'h1, m_low[5]});
    flag_step("R8 clear via pin word", 5, 0);
    pin_in[5] = 0; wait_cyc(5);
    pin_in[5] = 1; wait_cyc(5);
    flag_step("R9 rise again", 5, 1);
    bus_write(40, 32'h0000_0020);
    flag_step("R7 clear via flag word", 5, 0);
    pin_in[5] = 0; wait_cyc(5);

    // R3 lock released only by reset
    do_reset();
    bus_read(3, d); check("R3 reset clears lock", d, 32'h0);
    pcr_write(3, 32'h0000_4444);
    bus_read(3, d); check("R3 writable after reset", d, 32'h0000_4444);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule